// File: doc/BRIEF.md
# Two-Output PWM Action Qualifier with Continuous Software Override

This block turns time-base events into two PWM output levels, A and B. Every clock cycle in which the time base asserts its tick enable, the block looks at four event strobes: counter reached zero, counter reached period, counter matched compare A while counting up, and counter matched compare B while counting up. Each output has its own action word. The word assigns one of four actions to each event: no action, drive low, drive high or toggle. A flip-flop per output holds the resulting level.

A continuous software override can hold either output at a fixed level regardless of the events. Software writes the override code into a pending register. A separate reload-mode field selects when the pending code becomes the active one: on a zero event, on a period event, on either of them, or on the next tick. The action words, the reload mode and the pending override are written through a simple single-cycle write port. The counter, dead-band and trip-zone logic sit outside this block.

Top module: `pwm_action_qual`

## Requirements
- R1: Synchronous reset drives both outputs low and clears both action words, the reload mode, the pending override and the active override.
- R2: Action codes are 2'b00 no action (output holds), 2'b01 drive low, 2'b10 drive high and 2'b11 invert the present level; the new level is visible after the clock edge at which the tick and the event were sampled.
- R3: Output A's action word is at address 0 and output B's at address 1; within a word, bits 1:0 serve the zero event, bits 3:2 the period event, bits 5:4 the compare-A-up event and bits 9:8 the compare-B-up event. An event only applies its own field.
- R4: When several events arrive in the same tick, only the highest-priority event whose field is not 2'b00 acts. The priority order is zero, then period, then compare B, then compare A.
- R5: Event strobes in a cycle without tick have no effect on the outputs or on the active override.
- R6: The override register is at address 3. Bits 1:0 govern output A and bits 3:2 output B, where 2'b01 holds the output low, 2'b10 holds it high, and 2'b00 or 2'b11 leave it to the event actions. An active low or high code wins over every event action on each tick.
- R7: The reload mode is bits 7:6 at address 2. 2'b00 loads the pending override on a zero event, 2'b01 on a period event, 2'b10 on either, and 2'b11 on the next tick.
- R8: A pending override that has not been loaded has no effect. It already acts on the output in the tick in which it loads.
- R9: The action word 0x01A on A (0x10A on B) gives the normal pattern: high at zero and period, low at the own compare match. The word 0x025 gives the inverted pattern on A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base clock enable; events count only with it |
| evt_zero | input | 1 | Counter equals zero |
| evt_period | input | 1 | Counter equals period |
| evt_cmpa_up | input | 1 | Counter equals compare A while counting up |
| evt_cmpb_up | input | 1 | Counter equals compare B while counting up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 word A, 1 word B, 2 reload mode, 3 override) |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | Output A level |
| pwm_b | output | 1 | Output B level |

## Verification
The properties assume that the event strobes come from one time base, so that an event outside a tick is meaningless and only ticks may move the outputs or the active override. They also assume that a register write and a reload are never requested in the same cycle, because that case would make the loaded value depend on write ordering. The stimulus keeps these assumptions: each write takes a cycle of its own with tick low, and each tick is a separate cycle in which the events are driven together and then dropped.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  localparam int AQ_NUM_OUT = 2;
  localparam int AQ_NUM_EVT = 4;
  localparam int AQ_FLD_W   = 2 * AQ_NUM_EVT;
  localparam int AQ_FRC_W   = 2 * AQ_NUM_OUT;
  localparam int AQ_ADDR_W  = $clog2(AQ_NUM_OUT + 2);
  localparam int AQ_ADDR_RELOAD = AQ_NUM_OUT;
  localparam int AQ_ADDR_FORCE  = AQ_NUM_OUT + 1;
  localparam int AQ_RELOAD_LSB  = 6;
  localparam int AQ_WORD_USED   = 10;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RL_ZERO = 2'b00,
    RL_PRD  = 2'b01,
    RL_BOTH = 2'b10,
    RL_IMM  = 2'b11
  } reload_e;

  // Events are indexed in priority order: 0 zero, 1 period, 2 cmp B, 3 cmp A.
  // Returns the bit position of that event's field in a written action word.
  function automatic int evt_src_lsb(int idx);
    case (idx)
      0:       evt_src_lsb = 0;
      1:       evt_src_lsb = 2;
      2:       evt_src_lsb = 8;
      default: evt_src_lsb = 4;
    endcase
  endfunction

endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic [AQ_ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                    wr_data,
  output logic [AQ_NUM_OUT-1:0][AQ_FLD_W-1:0] act_fields,
  output logic [1:0]                           reload_mode,
  output logic [AQ_FRC_W-1:0]                  force_shadow
);

  logic unused_hi_bits;
  assign unused_hi_bits = ^wr_data[DATA_W-1:AQ_WORD_USED];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_fields   <= '0;
      reload_mode  <= RL_ZERO;
      force_shadow <= '0;
    end else if (wr_en) begin
      for (int o = 0; o < AQ_NUM_OUT; o++) begin
        if (wr_addr == AQ_ADDR_W'(o)) begin
          for (int i = 0; i < AQ_NUM_EVT; i++) begin
            act_fields[o][2*i +: 2] <= wr_data[evt_src_lsb(i) +: 2];
          end
        end
      end
      if (wr_addr == AQ_ADDR_W'(AQ_ADDR_RELOAD))
        reload_mode <= wr_data[AQ_RELOAD_LSB +: 2];
      if (wr_addr == AQ_ADDR_W'(AQ_ADDR_FORCE))
        force_shadow <= wr_data[AQ_FRC_W-1:0];
    end
  end

endmodule

// File: rtl/pwm_aq_force.sv
module pwm_aq_force
  import pwm_aq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                evt_zero,
  input  logic                evt_period,
  input  logic [1:0]          reload_mode,
  input  logic [AQ_FRC_W-1:0] force_shadow,
  output logic [AQ_FRC_W-1:0] force_act,
  output logic [AQ_FRC_W-1:0] force_eff
);

  logic load_now;

  always_comb begin
    load_now = 1'b0;
    if (tick) begin
      case (reload_e'(reload_mode))
        RL_ZERO: load_now = evt_zero;
        RL_PRD:  load_now = evt_period;
        RL_BOTH: load_now = evt_zero | evt_period;
        default: load_now = 1'b1;
      endcase
    end
  end

  // A code that loads in this tick already governs this tick's output.
  assign force_eff = load_now ? force_shadow : force_act;

  always_ff @(posedge clk) begin
    if (rst)           force_act <= '0;
    else if (load_now) force_act <= force_shadow;
  end

endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
  import pwm_aq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [AQ_NUM_EVT-1:0] evts,
  input  logic [AQ_FLD_W-1:0] fields,
  input  logic [1:0]          force_code,
  output logic                level
);

  act_e sel;
  logic nxt;

  // Walk from lowest to highest priority so the highest live event wins.
  always_comb begin
    sel = ACT_NONE;
    for (int i = AQ_NUM_EVT - 1; i >= 0; i--) begin
      if (evts[i] && (fields[2*i +: 2] != ACT_NONE))
        sel = act_e'(fields[2*i +: 2]);
    end
  end

  always_comb begin
    case (force_code)
      2'b01:   nxt = 1'b0;
      2'b10:   nxt = 1'b1;
      default: begin
        case (sel)
          ACT_LOW:    nxt = 1'b0;
          ACT_HIGH:   nxt = 1'b1;
          ACT_TOGGLE: nxt = ~level;
          default:    nxt = level;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       level <= 1'b0;
    else if (tick) level <= nxt;
  end

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 evt_zero,
  input  logic                 evt_period,
  input  logic                 evt_cmpa_up,
  input  logic                 evt_cmpb_up,
  input  logic                 wr_en,
  input  logic [AQ_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 pwm_a,
  output logic                 pwm_b
);

  logic [AQ_NUM_OUT-1:0][AQ_FLD_W-1:0] act_fields;
  logic [1:0]                          reload_mode;
  logic [AQ_FRC_W-1:0]                 force_shadow;
  logic [AQ_FRC_W-1:0]                 force_act;
  logic [AQ_FRC_W-1:0]                 force_eff;
  logic [AQ_NUM_EVT-1:0]               evts;
  logic [AQ_NUM_OUT-1:0]               levels;

  assign evts = {evt_cmpa_up, evt_cmpb_up, evt_period, evt_zero};

  pwm_aq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .act_fields   (act_fields),
    .reload_mode  (reload_mode),
    .force_shadow (force_shadow)
  );

  pwm_aq_force u_force (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .evt_zero     (evt_zero),
    .evt_period   (evt_period),
    .reload_mode  (reload_mode),
    .force_shadow (force_shadow),
    .force_act    (force_act),
    .force_eff    (force_eff)
  );

  for (genvar o = 0; o < AQ_NUM_OUT; o++) begin : g_chan
    pwm_aq_chan u_chan (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .evts       (evts),
      .fields     (act_fields[o]),
      .force_code (force_eff[2*o +: 2]),
      .level      (levels[o])
    );
  end

  assign pwm_a = levels[0];
  assign pwm_b = levels[1];

endmodule

// File: rtl/pwm_action_qual_chk.sv
module pwm_action_qual_chk
  import pwm_aq_pkg::*;
(
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 tick,
  input logic                                 evt_zero,
  input logic                                 pwm_a,
  input logic                                 pwm_b,
  input logic [AQ_NUM_OUT-1:0][AQ_FLD_W-1:0] act_fields,
  input logic [1:0]                           reload_mode,
  input logic [AQ_FRC_W-1:0]                  force_shadow,
  input logic [AQ_FRC_W-1:0]                  force_act,
  input logic [AQ_FRC_W-1:0]                  force_eff
);

  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (!pwm_a && !pwm_b));

  a_r5_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(pwm_a) && $stable(pwm_b)));

  a_r8_override_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(force_act));

  a_r7_imm_load: assert property (@(posedge clk) disable iff (rst)
    (tick && reload_mode == 2'b11) |=> (force_act == $past(force_shadow)));

  a_r6_force_a_low: assert property (@(posedge clk) disable iff (rst)
    (tick && force_eff[1:0] == 2'b01) |=> !pwm_a);

  a_r6_force_a_high: assert property (@(posedge clk) disable iff (rst)
    (tick && force_eff[1:0] == 2'b10) |=> pwm_a);

  a_r6_force_b_low: assert property (@(posedge clk) disable iff (rst)
    (tick && force_eff[3:2] == 2'b01) |=> !pwm_b);

  a_r6_force_b_high: assert property (@(posedge clk) disable iff (rst)
    (tick && force_eff[3:2] == 2'b10) |=> pwm_b);

  // R4: zero has top priority, so a zero event with a high action always wins.
  a_r4_zero_high_a: assert property (@(posedge clk) disable iff (rst)
    (tick && evt_zero && act_fields[0][1:0] == 2'b10 &&
     force_eff[1:0] != 2'b01 && force_eff[1:0] != 2'b10) |=> pwm_a);

endmodule

bind pwm_action_qual pwm_action_qual_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick         (tick),
  .evt_zero     (evt_zero),
  .pwm_a        (pwm_a),
  .pwm_b        (pwm_b),
  .act_fields   (act_fields),
  .reload_mode  (reload_mode),
  .force_shadow (force_shadow),
  .force_act    (force_act),
  .force_eff    (force_eff)
);

// File: tb/pwm_action_qual_bench.sv
`timescale 1ns/1ps
module pwm_action_qual_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        evt_zero = 1'b0;
  logic        evt_period = 1'b0;
  logic        evt_cmpa_up = 1'b0;
  logic        evt_cmpb_up = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a;
  logic        pwm_b;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  pwm_action_qual u_pwm_action_qual (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .evt_zero    (evt_zero),
    .evt_period  (evt_period),
    .evt_cmpa_up (evt_cmpa_up),
    .evt_cmpb_up (evt_cmpb_up),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .pwm_a       (pwm_a),
    .pwm_b       (pwm_b)
  );

  // {word A, word B, events {cmpB, cmpA, period, zero}, expected A, expected B}
  localparam logic [25:0] VEC [10] = '{
    {10'h002, 10'h000, 4'b0001, 1'b1, 1'b0},
    {10'h001, 10'h003, 4'b0001, 1'b0, 1'b1},
    {10'h008, 10'h008, 4'b0010, 1'b1, 1'b1},
    {10'h020, 10'h020, 4'b0100, 1'b1, 1'b1},
    {10'h200, 10'h200, 4'b1000, 1'b1, 1'b1},
    {10'h020, 10'h008, 4'b1000, 1'b0, 1'b0},
    {10'h009, 10'h108, 4'b1011, 1'b0, 1'b1},
    {10'h210, 10'h120, 4'b1100, 1'b1, 1'b0},
    {10'h008, 10'h002, 4'b1111, 1'b1, 1'b1},
    {10'h030, 10'h000, 4'b1111, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // ev = {cmpB, cmpA, period, zero}; outputs are read at the negedge after.
  task automatic do_tick(input logic tk, input logic [3:0] ev);
    @(negedge clk);
    tick = tk;
    {evt_cmpb_up, evt_cmpa_up, evt_period, evt_zero} = ev;
    @(negedge clk);
    tick = 1'b0;
    {evt_cmpb_up, evt_cmpa_up, evt_period, evt_zero} = 4'b0000;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 pwm_a after reset", pwm_a, 1'b0);
    chk("R1 pwm_b after reset", pwm_b, 1'b0);
    do_tick(1'b1, 4'b1111);
    chk("R1 cleared words, A", pwm_a, 1'b0);
    chk("R1 cleared words, B", pwm_b, 1'b0);

    // R2 R3 R4: table of single-tick patterns
    for (int k = 0; k < 10; k++) begin
      do_reset();
      do_write(2'd0, {6'd0, VEC[k][25:16]});
      do_write(2'd1, {6'd0, VEC[k][15:6]});
      do_tick(1'b1, VEC[k][5:2]);
      chk($sformatf("R2/R3/R4 vector %0d A", k), pwm_a, VEC[k][1]);
      chk($sformatf("R2/R3/R4 vector %0d B", k), pwm_b, VEC[k][0]);
    end

    // R5: events without tick are ignored
    do_reset();
    do_write(2'd0, 16'h0002);
    do_tick(1'b0, 4'b0001);
    chk("R5 no tick, A holds", pwm_a, 1'b0);
    do_tick(1'b1, 4'b0001);
    chk("R5 tick applies, A high", pwm_a, 1'b1);

    // R2: toggle twice
    do_reset();
    do_write(2'd0, 16'h0003);
    do_tick(1'b1, 4'b0001);
    chk("R2 toggle first", pwm_a, 1'b1);
    do_tick(1'b1, 4'b0001);
    chk("R2 toggle second", pwm_a, 1'b0);
    do_tick(1'b1, 4'b0000);
    chk("R2 no event holds", pwm_a, 1'b0);

    // R9: normal and inverted patterns
    do_reset();
    do_write(2'd0, 16'h001A);
    do_write(2'd1, 16'h010A);
    do_tick(1'b1, 4'b0001);
    chk("R9 zero A high", pwm_a, 1'b1);
    chk("R9 zero B high", pwm_b, 1'b1);
    do_tick(1'b1, 4'b0100);
    chk("R9 cmpA A low", pwm_a, 1'b0);
    chk("R9 cmpA B stays", pwm_b, 1'b1);
    do_tick(1'b1, 4'b1000);
    chk("R9 cmpB B low", pwm_b, 1'b0);
    do_tick(1'b1, 4'b0010);
    chk("R9 period A high", pwm_a, 1'b1);
    chk("R9 period B high", pwm_b, 1'b1);
    do_write(2'd0, 16'h0025);
    do_tick(1'b1, 4'b0001);
    chk("R9 inverted zero A low", pwm_a, 1'b0);
    do_tick(1'b1, 4'b0100);
    chk("R9 inverted cmpA A high", pwm_a, 1'b1);

    // R6 R7: immediate override
    do_reset();
    do_write(2'd0, 16'h0002);
    do_write(2'd1, 16'h0002);
    do_tick(1'b1, 4'b0001);
    do_write(2'd2, 16'h00C0);
    do_write(2'd3, 16'h0001);
    do_tick(1'b0, 4'b0001);
    chk("R8 pending, no tick, A holds", pwm_a, 1'b1);
    do_tick(1'b1, 4'b0000);
    chk("R6 force A low", pwm_a, 1'b0);
    chk("R6 B not forced", pwm_b, 1'b1);
    do_tick(1'b1, 4'b0001);
    chk("R6 force beats zero-high", pwm_a, 1'b0);
    do_write(2'd3, 16'h0003);
    do_tick(1'b1, 4'b0001);
    chk("R6 code 11 is no force", pwm_a, 1'b1);
    do_write(2'd1, 16'h0001);
    do_write(2'd3, 16'h0008);
    do_tick(1'b1, 4'b0001);
    chk("R6 force B high beats zero-low", pwm_b, 1'b1);

    // R7 R8: reload timing
    do_reset();
    do_write(2'd3, 16'h0002);
    do_tick(1'b1, 4'b0010);
    chk("R7 mode zero ignores period", pwm_a, 1'b0);
    do_tick(1'b1, 4'b0001);
    chk("R7 mode zero loads at zero", pwm_a, 1'b1);
    do_write(2'd2, 16'h0040);
    do_write(2'd3, 16'h0001);
    do_tick(1'b1, 4'b0001);
    chk("R7 mode period ignores zero", pwm_a, 1'b1);
    do_tick(1'b1, 4'b0010);
    chk("R7 mode period loads at period", pwm_a, 1'b0);
    do_write(2'd2, 16'h0080);
    do_write(2'd3, 16'h0002);
    do_tick(1'b1, 4'b0100);
    chk("R8 mode both, cmpA does not load", pwm_a, 1'b0);
    do_tick(1'b1, 4'b0001);
    chk("R7 mode both loads at zero", pwm_a, 1'b1);
    do_write(2'd3, 16'h0001);
    do_tick(1'b1, 4'b0010);
    chk("R7 mode both loads at period", pwm_a, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule